// File: doc/BRIEF.md
# Single to Half Precision Rounding Converter

This block narrows one 32-bit single-precision floating-point word into a 16-bit half-precision word in a single registered stage. Each accepted input is split into sign, exponent and fraction; special encodings (infinity, NaN, zero and single subnormals) take a short path. All other values are rounded under one of four selectable modes and then packed as a normal, a gradual-underflow subnormal, a flushed zero or an overflow result.

Two options travel with every input. The range option selects between the standard half format and an extended-range format. The extended-range format trades the infinity encoding for one extra exponent step and saturates on overflow. The early-tininess option makes a result that falls below the normal half range report underflow even when it is exact. Alongside the result word the block returns four exception flags: invalid, overflow, underflow and inexact.

Top module: `f2h_narrow`

## Requirements
- R1: While `rst` is high, and at the first edge after it, `out_valid`, `out_half` and all four flags are 0.
- R2: An input accepted with `in_valid` high at a clock edge appears on the outputs after that edge, with `out_valid` high for exactly that cycle. `out_valid` is low in every cycle that follows an edge without `in_valid`.
- R3: An input with stored exponent 255 gives half exponent field 31, fraction `in_word[22:13]`, and the input sign. For a NaN (nonzero fraction), result bit 9 is forced to 1. `out_invalid` is set only for a NaN whose bit 22 is 0. No other flag is raised, and the range option has no effect.
- R4: An input with stored exponent 0 gives a half zero with the input sign. If the fraction is nonzero, it raises both underflow and inexact; otherwise no flag is raised.
- R5: A value that fits exactly in the half normal range converts with no flag. For example, 0x3F800000 gives 0x3C00 and 0x477FE000 gives 0x7BFF.
- R6: Mode 0 (`rnd_mode`=2'd0) rounds to nearest. On an exact tie it rounds up only when the retained last bit is 1, and raises inexact.
- R7: Mode 1 adds a full discarded-field increment to positive values only. Mode 2 does the same for negative values only. Mode 3 always truncates. Any mode sets inexact when discarded bits are nonzero.
- R8: A rounding carry out of the 24-bit significand shifts the significand right by one and raises the exponent by one (0x3FFFF000 in mode 0 gives 0x4000).
- R9: In standard range (`alt_range`=0), a rounded unbiased exponent above 15 gives a signed infinity (field 31, fraction 0) and raises overflow and inexact, in every mode.
- R10: In extended range (`alt_range`=1), unbiased exponent 16 is a finite result with exponent field 31. An exponent above 16 gives the signed value 0x7FFF/0xFFFF and raises overflow and inexact.
- R11: The discard field is 13 bits for unbiased exponents of -14 and above. It widens by one bit for each step below -14. The result is denormalised to exponent field 0, or to 1 when rounding reaches the normal range. Underflow is raised when the value is tiny and bits are lost.
- R12: Unbiased exponents below -24 are clamped to -25 with all 23 fraction bits discarded. A result still below -24 after rounding is a signed zero with underflow and inexact set.
- R13: With `tiny_early`=1, a tiny result (unbiased exponent below -14 before rounding) raises underflow even when exact. With `tiny_early`=0, an exact tiny result raises no underflow.
- R14: A result rounded within the normal range raises inexact without underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word and options are accepted this cycle |
| in_word | input | 32 | Single-precision operand |
| rnd_mode | input | 2 | 0 nearest-even, 1 toward +inf, 2 toward -inf, 3 toward zero |
| alt_range | input | 1 | 1 selects the extended-range half format |
| tiny_early | input | 1 | 1 detects tininess before rounding |
| out_valid | output | 1 | Result and flags are valid |
| out_half | output | 16 | Half-precision result |
| out_invalid | output | 1 | Signaling NaN input |
| out_overflow | output | 1 | Result exceeded the format range |
| out_underflow | output | 1 | Tiny result |
| out_inexact | output | 1 | Result differs from the operand |

## Verification
The rounding carry and the overflow decision can fall in the same conversion. A value such as 65520 is a tie just under the top of the standard range: rounding up carries into exponent 16. That is an infinity in standard range and a finite field-31 value in extended range. The bench sends such tie and directed-mode inputs under both range settings, back to back. Its scoreboard compares the word and all four flags against a reference computed from the requirements.

// File: rtl/f2h_pkg.sv
package f2h_pkg;
  localparam int SP_W      = 32;
  localparam int SP_EXP_W  = 8;
  localparam int SP_FRAC_W = 23;
  localparam int SP_BIAS   = 127;
  localparam int HP_W      = 16;
  localparam int HP_EXP_W  = 5;
  localparam int HP_FRAC_W = 10;
  localparam int HP_BIAS   = 15;

  localparam int SIG_W     = SP_FRAC_W + 1;            // significand with hidden one
  localparam int DROP_W    = SP_FRAC_W - HP_FRAC_W;    // bits lost on a normal result
  localparam int EXP_W     = SP_EXP_W + 2;             // signed working exponent
  localparam int MIN_NORM_E = 1 - HP_BIAS;             // -14
  localparam int MIN_SUB_E  = MIN_NORM_E - HP_FRAC_W;  // -24
  localparam int MAX_STD_E  = HP_BIAS;                 // 15
  localparam int MAX_ALT_E  = HP_BIAS + 1;             // 16

  typedef enum logic [1:0] {
    RND_NEAR_EVEN = 2'd0,
    RND_UP        = 2'd1,
    RND_DOWN      = 2'd2,
    RND_ZERO      = 2'd3
  } rnd_e;

  typedef struct packed {
    logic                 sign;
    logic [SP_EXP_W-1:0]  exp;
    logic [SP_FRAC_W-1:0] frac;
  } sp_t;

  typedef struct packed {
    logic [HP_W-1:0] half;
    logic            invalid;
    logic            overflow;
    logic            underflow;
    logic            inexact;
  } res_t;
endpackage

// File: rtl/f2h_special.sv
module f2h_special
  import f2h_pkg::*;
(
  input  sp_t  op,
  output logic take,
  output res_t res
);
  localparam logic [SP_EXP_W-1:0] EXP_ONES = '1;
  localparam logic [SP_FRAC_W-1:0] QUIET_BIT = SP_FRAC_W'(1) << (SP_FRAC_W - 1);

  logic                 frac_nz;
  logic [SP_FRAC_W-1:0] frac_q;

  always_comb begin
    frac_nz = |op.frac;
    frac_q  = frac_nz ? (op.frac | QUIET_BIT) : op.frac;
    res     = '0;
    take    = 1'b0;
    if (op.exp == EXP_ONES) begin
      take        = 1'b1;
      res.half    = {op.sign, {HP_EXP_W{1'b1}}, HP_FRAC_W'(frac_q >> DROP_W)};
      res.invalid = frac_nz & ~op.frac[SP_FRAC_W-1];
    end else if (op.exp == '0) begin
      take          = 1'b1;
      res.half      = {op.sign, {(HP_W-1){1'b0}}};
      res.underflow = frac_nz;
      res.inexact   = frac_nz;
    end
  end
endmodule

// File: rtl/f2h_round.sv
module f2h_round
  import f2h_pkg::*;
(
  input  sp_t                     op,
  input  rnd_e                    mode,
  output logic [SIG_W-1:0]        sig_o,
  output logic signed [EXP_W-1:0] exp_o,
  output logic                    lost_o,
  output logic                    tiny_o
);
  localparam logic signed [EXP_W-1:0] E_MIN_NORM = EXP_W'(MIN_NORM_E);
  localparam logic signed [EXP_W-1:0] E_MIN_SUB  = EXP_W'(MIN_SUB_E);
  localparam logic signed [EXP_W-1:0] E_CLAMP    = EXP_W'(MIN_SUB_E - 1);
  localparam logic [SIG_W-1:0] FULL_MASK   = {1'b0, {SP_FRAC_W{1'b1}}};
  localparam logic [SIG_W-1:0] NORMAL_MASK = SIG_W'((1 << DROP_W) - 1);

  logic signed [EXP_W-1:0] e_unb;
  logic signed [EXP_W-1:0] e_use;
  logic [EXP_W-1:0]        sh;
  logic [SIG_W-1:0]        sig, mask, rem, half_ulp, inc;
  logic [SIG_W:0]          sum;

  always_comb begin
    e_unb  = $signed(EXP_W'(op.exp)) - $signed(EXP_W'(SP_BIAS));
    e_use  = e_unb;
    sig    = {1'b1, op.frac};
    tiny_o = e_unb < E_MIN_NORM;
    sh     = e_unb - E_MIN_SUB;
    if (e_unb < E_MIN_SUB) begin
      e_use = E_CLAMP;
      mask  = FULL_MASK;
    end else if (tiny_o) begin
      mask  = FULL_MASK >> sh;
    end else begin
      mask  = NORMAL_MASK;
    end
    rem      = sig & mask;
    lost_o   = |rem;
    half_ulp = (mask + SIG_W'(1)) >> 1;
    case (mode)
      RND_NEAR_EVEN: inc = (rem == half_ulp) ? (sig & (half_ulp << 1)) : half_ulp;
      RND_UP:        inc = op.sign ? '0 : mask;
      RND_DOWN:      inc = op.sign ? mask : '0;
      default:       inc = '0;
    endcase
    if (!lost_o) inc = '0;
    sum = {1'b0, sig} + {1'b0, inc};
    if (sum[SIG_W]) begin
      sig_o = sum[SIG_W:1];
      exp_o = e_use + EXP_W'(1);
    end else begin
      sig_o = sum[SIG_W-1:0];
      exp_o = e_use;
    end
  end
endmodule

// File: rtl/f2h_pack.sv
module f2h_pack
  import f2h_pkg::*;
(
  input  logic                    sign,
  input  logic [SIG_W-1:0]        sig_i,
  input  logic signed [EXP_W-1:0] exp_i,
  input  logic                    lost_i,
  input  logic                    tiny_i,
  input  logic                    alt_range,
  input  logic                    tiny_early,
  output res_t                    res
);
  localparam logic signed [EXP_W-1:0] E_MIN_NORM = EXP_W'(MIN_NORM_E);
  localparam logic signed [EXP_W-1:0] E_MIN_SUB  = EXP_W'(MIN_SUB_E);
  localparam logic signed [EXP_W-1:0] E_MAX_STD  = EXP_W'(MAX_STD_E);
  localparam logic signed [EXP_W-1:0] E_MAX_ALT  = EXP_W'(MAX_ALT_E);
  localparam int TOP_W = SIG_W - DROP_W;
  localparam int PAD_W = HP_W - 1 - TOP_W;

  logic signed [EXP_W-1:0] thr;
  logic [EXP_W-1:0]        dsh;
  logic [SIG_W-1:0]        sig_sh;
  logic [TOP_W-1:0]        top_bits;
  logic [HP_EXP_W-1:0]     ef;
  logic [HP_W-2:0]         body;

  always_comb begin
    res      = '0;
    thr      = alt_range ? E_MAX_ALT : E_MAX_STD;
    dsh      = E_MIN_NORM - exp_i;
    sig_sh   = sig_i;
    ef       = HP_EXP_W'(exp_i - E_MIN_NORM);
    if (exp_i < E_MIN_NORM) begin
      sig_sh = sig_i >> dsh;
      ef     = '0;
    end
    top_bits = TOP_W'(sig_sh >> DROP_W);
    body     = {ef, {HP_FRAC_W{1'b0}}} + {{PAD_W{1'b0}}, top_bits};
    if (exp_i > thr) begin
      res.half     = {sign, {HP_EXP_W{1'b1}},
                      alt_range ? {HP_FRAC_W{1'b1}} : {HP_FRAC_W{1'b0}}};
      res.overflow = 1'b1;
      res.inexact  = 1'b1;
    end else if (exp_i < E_MIN_SUB) begin
      res.half      = {sign, {(HP_W-1){1'b0}}};
      res.underflow = 1'b1;
      res.inexact   = 1'b1;
    end else begin
      res.half      = {sign, body};
      res.inexact   = lost_i;
      res.underflow = tiny_i & (lost_i | tiny_early);
    end
  end
endmodule

// File: rtl/f2h_narrow.sv
module f2h_narrow
  import f2h_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [31:0] in_word,
  input  logic [1:0]  rnd_mode,
  input  logic        alt_range,
  input  logic        tiny_early,
  output logic        out_valid,
  output logic [15:0] out_half,
  output logic        out_invalid,
  output logic        out_overflow,
  output logic        out_underflow,
  output logic        out_inexact
);
  sp_t                     op;
  logic                    sp_take;
  res_t                    sp_res, nm_res, res_d, res_q;
  logic [SIG_W-1:0]        r_sig;
  logic signed [EXP_W-1:0] r_exp;
  logic                    r_lost, r_tiny;
  logic                    valid_q;

  assign op = sp_t'(in_word);

  f2h_special u_special (
    .op   (op),
    .take (sp_take),
    .res  (sp_res)
  );

  f2h_round u_round (
    .op     (op),
    .mode   (rnd_e'(rnd_mode)),
    .sig_o  (r_sig),
    .exp_o  (r_exp),
    .lost_o (r_lost),
    .tiny_o (r_tiny)
  );

  f2h_pack u_pack (
    .sign       (op.sign),
    .sig_i      (r_sig),
    .exp_i      (r_exp),
    .lost_i     (r_lost),
    .tiny_i     (r_tiny),
    .alt_range  (alt_range),
    .tiny_early (tiny_early),
    .res        (nm_res)
  );

  assign res_d = sp_take ? sp_res : nm_res;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) res_q <= res_d;
    end
  end

  assign out_valid     = valid_q;
  assign out_half      = res_q.half;
  assign out_invalid   = res_q.invalid;
  assign out_overflow  = res_q.overflow;
  assign out_underflow = res_q.underflow;
  assign out_inexact   = res_q.inexact;
endmodule

// File: rtl/f2h_narrow_chk.sv
module f2h_narrow_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_sign,
  input logic        alt_range,
  input logic        out_valid,
  input logic [15:0] out_half,
  input logic        out_invalid,
  input logic        out_overflow,
  input logic        out_underflow,
  input logic        out_inexact
);
  // R2: one-cycle handshake in both directions
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R3: invalid only on a NaN-shaped quiet result
  a_r3_invalid_nan: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_invalid) |-> (out_half[14:10] == 5'h1f && out_half[9]));
  // R4: sign always carried through
  a_r4_sign_kept: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_half[15] == $past(in_sign)));
  // R9: overflow implies inexact and a standard-range infinity
  a_r9_ovf_inexact: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_overflow) |-> out_inexact);
  a_r9_std_infinity: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_overflow && !$past(alt_range)) |-> (out_half[14:0] == 15'h7c00));
  // R10: extended range saturates
  a_r10_alt_saturate: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_overflow && $past(alt_range)) |-> (out_half[14:0] == 15'h7fff));
  // R11: underflow only with a tiny-sized result
  a_r11_unf_small: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_underflow) |-> (out_half[14:10] <= 5'd1 && !out_overflow));
endmodule

bind f2h_narrow f2h_narrow_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .in_sign       (in_word[31]),
  .alt_range     (alt_range),
  .out_valid     (out_valid),
  .out_half      (out_half),
  .out_invalid   (out_invalid),
  .out_overflow  (out_overflow),
  .out_underflow (out_underflow),
  .out_inexact   (out_inexact)
);

// File: tb/test_f2h_narrow.sv
module test_f2h_narrow;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic [1:0]  rnd_mode = '0;
  logic        alt_range = 1'b0;
  logic        tiny_early = 1'b0;
  logic        out_valid;
  logic [15:0] out_half;
  logic        out_invalid, out_overflow, out_underflow, out_inexact;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [19:0] q_exp[$];
  string       q_tag[$];

  always #5 clk = ~clk;

  f2h_narrow i_f2h_narrow (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .rnd_mode(rnd_mode), .alt_range(alt_range), .tiny_early(tiny_early),
    .out_valid(out_valid), .out_half(out_half), .out_invalid(out_invalid),
    .out_overflow(out_overflow), .out_underflow(out_underflow),
    .out_inexact(out_inexact)
  );

  // Reference: {half, invalid, overflow, underflow, inexact}
  function automatic logic [19:0] model(input logic [31:0] w, input logic [1:0] m,
                                        input logic alt, input logic te);
    logic [31:0] fr, sig, rem, hf, inc, body;
    int ex, e, sh;
    logic s, inv, ovf, unf, inx, tiny;
    s = w[31]; ex = int'(w[30:23]); fr = {9'd0, w[22:0]};
    inv = 0; ovf = 0; unf = 0; inx = 0;
    if (ex == 255) begin
      if (fr != 0) begin inv = ~w[22]; fr = fr | 32'h400000; end
      return {s, 5'h1f, fr[22:13], inv, 1'b0, 1'b0, 1'b0};
    end
    if (ex == 0) return {s, 15'd0, 1'b0, 1'b0, fr != 0, fr != 0};
    e = ex - 127; tiny = (e < -14);
    sig = fr | 32'h800000;
    if (e < -24) begin e = -25; sh = 23; end
    else if (e < -14) sh = -1 - e;
    else sh = 13;
    rem = sig & ((32'd1 << sh) - 1);
    hf  = 32'd1 << (sh - 1);
    inc = 0;
    if (rem != 0) begin
      case (m)
        2'd0: inc = (rem == hf) ? (sig & (32'd1 << sh)) : hf;
        2'd1: inc = s ? 0 : (32'd1 << sh) - 1;
        2'd2: inc = s ? (32'd1 << sh) - 1 : 0;
        default: inc = 0;
      endcase
    end
    inx = (rem != 0);
    sig = sig + inc;
    if (sig >= 32'h1000000) begin sig = sig >> 1; e = e + 1; end
    if (e > (alt ? 16 : 15))
      return {s, alt ? 15'h7fff : 15'h7c00, 1'b0, 1'b1, 1'b0, 1'b1};
    if (e < -24) return {s, 15'd0, 1'b0, 1'b0, 1'b1, 1'b1};
    if (e < -14) begin sig = sig >> (-14 - e); e = -14; end
    body = (32'(e + 14) << 10) + (sig >> 13);
    unf = tiny && (inx || te);
    return {s, body[14:0], 1'b0, 1'b0, unf, inx};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic drive(input logic [31:0] w, input logic [1:0] m, input logic alt,
                       input logic te, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_word = w; rnd_mode = m; alt_range = alt; tiny_early = te;
    q_exp.push_back(model(w, m, alt, te));
    q_tag.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor / scoreboard
  always @(posedge clk) begin
    #2;
    if (!rst && out_valid) begin
      if (q_exp.size() == 0) begin
        check("R2 unexpected", 32'd1, 32'd0);
      end else begin
        logic [19:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        check(t, {12'd0, out_half, out_invalid, out_overflow, out_underflow, out_inexact},
              {12'd0, e});
      end
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset", {11'd0, out_valid, out_half, out_invalid, out_overflow,
                       out_underflow, out_inexact}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", {31'd0, out_valid}, 32'd0);

    // R5: exact normals
    drive(32'h3F800000, 2'd0, 0, 0, "R5 one");
    drive(32'hC0000000, 2'd0, 0, 0, "R5 minus two");
    drive(32'h477FE000, 2'd0, 0, 0, "R5 max finite");
    // R6: nearest-even ties
    drive(32'h3F801000, 2'd0, 0, 0, "R6 tie even down");
    drive(32'h3F803000, 2'd0, 0, 0, "R6 tie odd up");
    drive(32'h3F801001, 2'd0, 0, 0, "R14 above tie in range");
    // R7: directed modes
    drive(32'h3F800001, 2'd1, 0, 0, "R7 up positive");
    drive(32'h3F800001, 2'd2, 0, 0, "R7 down positive");
    drive(32'hBF800001, 2'd2, 0, 0, "R7 down negative");
    drive(32'hBF800001, 2'd1, 0, 0, "R7 up negative");
    drive(32'hBF800FFF, 2'd3, 0, 0, "R7 toward zero");
    // R8: carry
    drive(32'h3FFFF000, 2'd0, 0, 0, "R8 carry to two");
    drive(32'hBFFFE001, 2'd2, 0, 0, "R8 carry negative");
    idle();
    @(negedge clk);
    check("R2 idle gap", {31'd0, out_valid}, 32'd0);
    // R9: standard overflow, carry meets threshold
    drive(32'h477FF000, 2'd0, 0, 0, "R9 tie rounds to inf");
    drive(32'h47C35000, 2'd0, 0, 0, "R9 large");
    drive(32'hC7800000, 2'd3, 0, 0, "R9 toward zero still inf");
    // R10: extended range
    drive(32'h477FF000, 2'd0, 1, 0, "R10 tie in alt range");
    drive(32'h47800000, 2'd0, 1, 0, "R10 exp 16 finite");
    drive(32'h47FFE000, 2'd0, 1, 0, "R10 alt max");
    drive(32'h48000000, 2'd0, 1, 0, "R10 alt saturate");
    drive(32'hC8000000, 2'd1, 1, 0, "R10 alt saturate negative");
    // R3: specials
    drive(32'h7F800000, 2'd0, 0, 0, "R3 inf");
    drive(32'hFFC00001, 2'd0, 0, 0, "R3 quiet nan");
    drive(32'h7F800001, 2'd0, 0, 0, "R3 signaling nan");
    drive(32'h7FA00000, 2'd1, 1, 0, "R3 signaling nan alt");
    drive(32'hFF800000, 2'd0, 1, 0, "R3 neg inf alt");
    // R4: zero and subnormal input
    drive(32'h00000000, 2'd0, 0, 1, "R4 zero");
    drive(32'h80000000, 2'd1, 0, 0, "R4 neg zero");
    drive(32'h00000001, 2'd1, 0, 0, "R4 sub flushed");
    drive(32'h80400000, 2'd0, 0, 0, "R4 neg sub");
    // R11: gradual underflow
    drive(32'h33800000, 2'd0, 0, 0, "R11 min sub exact");
    drive(32'h38000000, 2'd0, 0, 0, "R11 sub exact");
    drive(32'h33C00000, 2'd0, 0, 0, "R11 sub tie");
    drive(32'h387FF000, 2'd0, 0, 0, "R11 sub rounds to normal");
    drive(32'hB8123456, 2'd2, 0, 0, "R11 sub directed");
    // R12: clamp and flush
    drive(32'h33000000, 2'd0, 0, 0, "R12 half of min sub");
    drive(32'h2F800000, 2'd1, 0, 0, "R12 deep up");
    drive(32'h33000001, 2'd1, 0, 0, "R12 clamp carry");
    drive(32'hB3400000, 2'd0, 0, 0, "R12 clamp tie");
    // R13: tininess option
    drive(32'h33800000, 2'd0, 0, 1, "R13 exact tiny early");
    drive(32'h38800000, 2'd0, 0, 1, "R13 min normal not tiny");
    drive(32'h387FF000, 2'd0, 0, 1, "R13 rounds into normal");
    drive(32'h38000000, 2'd0, 1, 1, "R13 exact sub early");
    idle();
    repeat (3) @(negedge clk);
    check("R2 queue drained", q_exp.size(), 32'd0);
    check("R2 idle", {31'd0, out_valid}, 32'd0);
    done = 1;
    summary();
    $finish;
  end
endmodule